// File: doc/BRIEF.md
# Configurable Registered 16x16 Multiplier

This block multiplies two 16-bit operands and returns a 32-bit product. Each operand sits in its own input register. Each input register also stores a signedness flag for its operand, so a product can be signed by signed, unsigned by unsigned, or mixed. Each operand register has an active-high hold input that stops it from loading. A round request is captured next to the operands. When it is set, the block adds one at bit 15 of the formatted product. Keeping only the upper half then gives a result rounded to 16 bits.

The formatted product goes into a 32-bit result register, which has its own hold control. A bypass mode lets the formatted value reach the outputs without passing through that register. A shift-format control selects one of two layouts:

- the plain 32-bit product, or
- a layout that drops the redundant sign bit and repeats the sign at the top of the lower half.

The upper output port carries either result half, chosen by a select line. Each output port has an active-low enable, and the block reports it as a valid flag. The result MSB is also provided in true and inverted form, which helps when building wider multipliers.

Top module: `mul16_cfg_top`

## Requirements
- R1: On a rising edge with `hold_a` low, the A register loads `a_in` and `a_signed`. With `hold_a` high, both keep their previous values.
- R2: On a rising edge with `hold_b` low, the B register loads `b_in` and `b_signed`. With `hold_b` high, both keep their previous values.
- R3: A flag value of 1 treats that operand as two's complement, and 0 treats it as unsigned. The product is the low 32 bits of the exact product of the two interpreted values, for any mix of flags.
- R4: The round request `round_en` is captured on a rising edge only when at least one of `hold_a` or `hold_b` is low. Otherwise the previously captured value is kept.
- R5: When the captured round request is 1, the value 0x00008000 is added to the formatted 32-bit result. The sum wraps modulo 2^32.
- R6: With `full_fmt` = 1, upper half = P[31:16] and lower half = P[15:0].
- R7: With `full_fmt` = 0, upper half = P[30:15] and lower half = {P[31], P[14:0]}.
- R8: On a rising edge with `hold_res` low, the result register loads the formatted value. With `hold_res` high, it keeps its value. In registered mode, a result appears after the second rising edge following operand capture.
- R9: With `bypass` = 1 and `hold_res` = 0, the outputs show the formatted value computed from the current operand registers and the current `full_fmt`, without waiting for the result register.
- R10: `msp_sel_lo` = 0 places the upper half on `msp_out`, and `msp_sel_lo` = 1 places the lower half on it. `lsp_out` always carries the lower half.
- R11: `oe_msp_n` and `oe_lsp_n` are active low. When one is high, the matching data output is 0 and its valid flag is 0.
- R12: `msb_out` equals bit 31 of the shown result, and `msb_out_n` is its complement. Neither output is gated by an enable.
- R13: A synchronous active-high `rst` clears the operand, round and result registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Operand A data |
| a_signed | input | 1 | Operand A is two's complement when 1 |
| hold_a | input | 1 | Blocks loading of A register when 1 |
| b_in | input | 16 | Operand B data |
| b_signed | input | 1 | Operand B is two's complement when 1 |
| hold_b | input | 1 | Blocks loading of B register when 1 |
| round_en | input | 1 | Round request, captured with operands |
| full_fmt | input | 1 | 1: full 32-bit layout; 0: sign-shifted layout |
| hold_res | input | 1 | Blocks loading of result register when 1 |
| bypass | input | 1 | Feed formatted result past the result register |
| msp_sel_lo | input | 1 | Select lower half onto `msp_out` |
| oe_msp_n | input | 1 | Active-low enable of `msp_out` |
| oe_lsp_n | input | 1 | Active-low enable of `lsp_out` |
| msp_out | output | 16 | Selected result half |
| msp_valid | output | 1 | `msp_out` enabled |
| lsp_out | output | 16 | Lower result half |
| lsp_valid | output | 1 | `lsp_out` enabled |
| msb_out | output | 1 | Result bit 31 |
| msb_out_n | output | 1 | Inverted result bit 31 |

## Verification
A wrong operand register or a lost signedness flag corrupts the product one edge later. It is visible at the ports after the second edge in registered mode, and directly after the capturing edge in bypass mode. A round flag stuck at the wrong value moves the output by exactly 0x8000, and a result register that loads while holding shows a changed value on the very next cycle. The bench compares every cycle against a model that is built only from the requirements, so any such error shows up within two cycles of the stimulus that exposes it.

// File: rtl/mulcfg_pkg.sv
package mulcfg_pkg;

    parameter int unsigned OP_W  = 16;
    localparam int unsigned RES_W = 2 * OP_W;
    localparam int unsigned EXT_W = OP_W + 1;

    typedef struct packed {
        logic            is_signed;
        logic [OP_W-1:0] val;
    } operand_t;

    typedef struct packed {
        logic [OP_W-1:0] hi;
        logic [OP_W-1:0] lo;
    } result_t;

    localparam logic [RES_W-1:0] ROUND_INC = RES_W'(1) << (OP_W - 1);

    // Widen an operand by one bit, sign or zero filled per its flag.
    function automatic logic [EXT_W-1:0] widen(operand_t o);
        return {o.is_signed & o.val[OP_W-1], o.val};
    endfunction

    // Arrange a raw product into one of the two output layouts.
    function automatic result_t arrange(logic [RES_W-1:0] p, logic full);
        result_t r;
        if (full) begin
            r = result_t'(p);
        end else begin
            r = result_t'({p[RES_W-2:OP_W-1], p[RES_W-1], p[OP_W-2:0]});
        end
        return r;
    endfunction

endpackage

// File: rtl/mulcfg_operand_reg.sv
module mulcfg_operand_reg
    import mulcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic [OP_W-1:0] d_val,
    input  logic            d_sgn,
    output operand_t        q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (!hold) begin
            q.val       <= d_val;
            q.is_signed <= d_sgn;
        end
    end

    // R1/R2: holding freezes the register
    a_r1_operand_hold: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(q));

    // R1/R2: a load takes the presented data and flag
    a_r2_operand_load: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (q.val == $past(d_val) && q.is_signed == $past(d_sgn)));

endmodule

// File: rtl/mulcfg_core.sv
module mulcfg_core
    import mulcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold_a,
    input  logic     hold_b,
    input  logic     round_in,
    input  logic     full_fmt,
    input  operand_t op_a,
    input  operand_t op_b,
    output result_t  fmt_out
);

    logic                      rnd_q;
    logic signed [EXT_W-1:0]   ext_a;
    logic signed [EXT_W-1:0]   ext_b;
    logic signed [2*EXT_W-1:0] prod_wide;
    logic [RES_W-1:0]          prod;
    result_t                   laid_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            rnd_q <= 1'b0;
        end else if (!(hold_a && hold_b)) begin
            rnd_q <= round_in;
        end
    end

    always_comb begin
        ext_a     = $signed(widen(op_a));
        ext_b     = $signed(widen(op_b));
        prod_wide = ext_a * ext_b;
        prod      = prod_wide[RES_W-1:0];
        laid_out  = arrange(prod, full_fmt);
        fmt_out   = result_t'(laid_out + (rnd_q ? ROUND_INC : '0));
    end

    // R4: round request is frozen while both operand registers hold
    a_r4_round_hold: assert property (@(posedge clk) disable iff (rst)
        (hold_a && hold_b) |=> $stable(rnd_q));

    a_r4_round_load: assert property (@(posedge clk) disable iff (rst)
        !(hold_a && hold_b) |=> (rnd_q == $past(round_in)));

endmodule

// File: rtl/mulcfg_result_stage.sv
module mulcfg_result_stage
    import mulcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            bypass,
    input  logic            sel_lo,
    input  logic            oe_hi_n,
    input  logic            oe_lo_n,
    input  result_t         fmt_in,
    output logic [OP_W-1:0] msp_out,
    output logic            msp_valid,
    output logic [OP_W-1:0] lsp_out,
    output logic            lsp_valid,
    output logic            msb_out,
    output logic            msb_out_n
);

    result_t res_q;
    result_t shown;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (!hold) begin
            res_q <= fmt_in;
        end
    end

    always_comb begin
        shown     = (bypass && !hold) ? fmt_in : res_q;
        msp_valid = !oe_hi_n;
        lsp_valid = !oe_lo_n;
        msp_out   = oe_hi_n ? '0 : (sel_lo ? shown.lo : shown.hi);
        lsp_out   = oe_lo_n ? '0 : shown.lo;
        msb_out   = shown.hi[OP_W-1];
        msb_out_n = ~shown.hi[OP_W-1];
    end

    // R8: result register holds and loads
    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(res_q));

    a_r8_result_load: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (res_q == $past(fmt_in)));

    // R11: a disabled port reads zero and invalid
    a_r11_oe_gate: assert property (@(posedge clk) disable iff (rst)
        oe_hi_n |-> (msp_out == '0 && !msp_valid));

    // R10: with both ports on and lower half selected, both ports agree
    a_r10_sel_lo: assert property (@(posedge clk) disable iff (rst)
        (!oe_hi_n && !oe_lo_n && sel_lo) |-> (msp_out == lsp_out));

endmodule

// File: rtl/mul16_cfg_top.sv
module mul16_cfg_top
    import mulcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] a_in,
    input  logic            a_signed,
    input  logic            hold_a,
    input  logic [OP_W-1:0] b_in,
    input  logic            b_signed,
    input  logic            hold_b,
    input  logic            round_en,
    input  logic            full_fmt,
    input  logic            hold_res,
    input  logic            bypass,
    input  logic            msp_sel_lo,
    input  logic            oe_msp_n,
    input  logic            oe_lsp_n,
    output logic [OP_W-1:0] msp_out,
    output logic            msp_valid,
    output logic [OP_W-1:0] lsp_out,
    output logic            lsp_valid,
    output logic            msb_out,
    output logic            msb_out_n
);

    localparam int unsigned N_OPS = 2;

    logic [N_OPS-1:0]           hold_v;
    logic [N_OPS-1:0]           sgn_v;
    logic [N_OPS-1:0][OP_W-1:0] val_v;
    operand_t                   ops [N_OPS];
    result_t                    fmt;

    assign hold_v = {hold_b, hold_a};
    assign sgn_v  = {b_signed, a_signed};
    assign val_v  = {b_in, a_in};

    generate
        for (genvar i = 0; i < N_OPS; i++) begin : g_op
            mulcfg_operand_reg u_reg (
                .clk   (clk),
                .rst   (rst),
                .hold  (hold_v[i]),
                .d_val (val_v[i]),
                .d_sgn (sgn_v[i]),
                .q     (ops[i])
            );
        end
    endgenerate

    mulcfg_core u_core (
        .clk      (clk),
        .rst      (rst),
        .hold_a   (hold_a),
        .hold_b   (hold_b),
        .round_in (round_en),
        .full_fmt (full_fmt),
        .op_a     (ops[0]),
        .op_b     (ops[1]),
        .fmt_out  (fmt)
    );

    mulcfg_result_stage u_res (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold_res),
        .bypass    (bypass),
        .sel_lo    (msp_sel_lo),
        .oe_hi_n   (oe_msp_n),
        .oe_lo_n   (oe_lsp_n),
        .fmt_in    (fmt),
        .msp_out   (msp_out),
        .msp_valid (msp_valid),
        .lsp_out   (lsp_out),
        .lsp_valid (lsp_valid),
        .msb_out   (msb_out),
        .msb_out_n (msb_out_n)
    );

    // R12: true and inverted MSB never agree
    a_r12_msb_pair: assert property (@(posedge clk) disable iff (rst)
        msb_out != msb_out_n);

endmodule

// File: tb/tb_mul16_cfg_top.sv
module tb_mul16_cfg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in = '0, b_in = '0;
    logic        a_signed = 0, b_signed = 0, hold_a = 0, hold_b = 0;
    logic        round_en = 0, full_fmt = 1, hold_res = 0, bypass = 0;
    logic        msp_sel_lo = 0, oe_msp_n = 0, oe_lsp_n = 0;
    logic [15:0] msp_out, lsp_out;
    logic        msp_valid, lsp_valid, msb_out, msb_out_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model state
    logic [15:0] m_a, m_b;
    logic        m_as, m_bs, m_rnd;
    logic [31:0] m_res;

    always #10 clk = ~clk;

    mul16_cfg_top dut (
        .clk(clk), .rst(rst), .a_in(a_in), .a_signed(a_signed), .hold_a(hold_a),
        .b_in(b_in), .b_signed(b_signed), .hold_b(hold_b), .round_en(round_en),
        .full_fmt(full_fmt), .hold_res(hold_res), .bypass(bypass),
        .msp_sel_lo(msp_sel_lo), .oe_msp_n(oe_msp_n), .oe_lsp_n(oe_lsp_n),
        .msp_out(msp_out), .msp_valid(msp_valid), .lsp_out(lsp_out),
        .lsp_valid(lsp_valid), .msb_out(msb_out), .msb_out_n(msb_out_n)
    );

    function automatic logic [31:0] ref_fmt(logic [15:0] a, logic as_, logic [15:0] b,
                                            logic bs, logic r, logic full);
        longint sa, sb, p;
        logic [31:0] p32, f;
        sa  = as_ ? longint'($signed(a)) : longint'(a);
        sb  = bs  ? longint'($signed(b)) : longint'(b);
        p   = sa * sb;
        p32 = p[31:0];
        f   = full ? p32 : {p32[30:15], p32[31], p32[14:0]};
        return f + (r ? 32'h0000_8000 : 32'h0);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_ports(string tag);
        logic [31:0] src;
        logic [15:0] e_msp, e_lsp;
        src = (bypass && !hold_res) ? ref_fmt(m_a, m_as, m_b, m_bs, m_rnd, full_fmt) : m_res;
        e_msp = oe_msp_n ? 16'h0 : (msp_sel_lo ? src[15:0] : src[31:16]);
        e_lsp = oe_lsp_n ? 16'h0 : src[15:0];
        chk({tag, " msp"}, {16'h0, msp_out}, {16'h0, e_msp});
        chk({tag, " lsp"}, {16'h0, lsp_out}, {16'h0, e_lsp});
        chk("R11 valid", {30'h0, msp_valid, lsp_valid}, {30'h0, !oe_msp_n, !oe_lsp_n});
        chk("R12 msb", {30'h0, msb_out, msb_out_n}, {30'h0, src[31], ~src[31]});
    endtask

    // one clock: edge, update model, check at the falling edge
    task automatic step(string tag);
        logic [31:0] f;
        @(posedge clk);
        f = ref_fmt(m_a, m_as, m_b, m_bs, m_rnd, full_fmt);
        if (rst) begin
            m_a = 0; m_b = 0; m_as = 0; m_bs = 0; m_rnd = 0; m_res = 0;
        end else begin
            if (!hold_res) m_res = f;
            if (!(hold_a && hold_b)) m_rnd = round_en;
            if (!hold_a) begin m_a = a_in; m_as = a_signed; end
            if (!hold_b) begin m_b = b_in; m_bs = b_signed; end
        end
        @(negedge clk);
        check_ports(tag);
    endtask

    task automatic set_ops(logic [15:0] a, logic as_, logic [15:0] b, logic bs, logic r);
        a_in = a; a_signed = as_; b_in = b; b_signed = bs; round_en = r;
    endtask

    task automatic quiet();
        hold_a = 0; hold_b = 0; hold_res = 0; bypass = 0;
        msp_sel_lo = 0; oe_msp_n = 0; oe_lsp_n = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_a = 'x; m_b = 'x;
        // R13: reset clears everything
        set_ops(16'h1234, 1, 16'h5678, 0, 1);
        rst = 1;
        step("R13");
        step("R13");
        @(negedge clk);
        chk("R13 msp", {16'h0, msp_out}, 32'h0);
        chk("R13 lsp", {16'h0, lsp_out}, 32'h0);
        rst = 0;

        // R8: two-edge latency, R6 full layout, R3 unsigned
        full_fmt = 1;
        set_ops(16'hFFFF, 0, 16'hFFFF, 0, 0);
        step("R8"); step("R6"); step("R3");
        chk("R3 unsigned product", {msp_out, lsp_out}, 32'hFFFE_0001);

        // R3: mixed flags, -1 * 65535
        set_ops(16'hFFFF, 1, 16'hFFFF, 0, 0);
        step("R3"); step("R3");
        chk("R3 mixed product", {msp_out, lsp_out}, 32'hFFFF_0001);

        // R7: sign-shifted layout of min*min
        full_fmt = 0;
        set_ops(16'h8000, 1, 16'h8000, 1, 0);
        step("R7"); step("R7");
        chk("R7 shifted layout", {msp_out, lsp_out}, 32'h8000_0000);

        // R5: round wraps modulo 2^32 (-1 * 1 + 0x8000)
        full_fmt = 1;
        set_ops(16'hFFFF, 1, 16'h0001, 0, 1);
        step("R5"); step("R5");
        chk("R5 round wrap", {msp_out, lsp_out}, 32'h0000_7FFF);

        // R4: round captured only when some operand register loads
        hold_a = 1; hold_b = 1;
        set_ops(16'h0001, 0, 16'h0001, 0, 0);
        step("R4"); step("R4");
        chk("R4 round kept", {msp_out, lsp_out}, 32'h0000_7FFF);
        // R1/R2: operands unchanged while held; free one side
        hold_a = 0;
        step("R1"); step("R2");
        chk("R2 b held, a loaded", {msp_out, lsp_out}, 32'h0000_0001);
        hold_a = 1; hold_b = 0;
        set_ops(16'h0002, 0, 16'h0003, 0, 0);
        step("R2"); step("R1");
        chk("R1 a held, b loaded", {msp_out, lsp_out}, 32'h0000_0003);
        quiet();

        // R8: result hold, R9: bypass, R10: select, R11: enables
        hold_res = 1;
        set_ops(16'h0100, 0, 16'h0100, 0, 0);
        step("R8"); step("R8");
        chk("R8 result held", {msp_out, lsp_out}, 32'h0000_0003);
        hold_res = 0; bypass = 1;
        set_ops(16'h0200, 0, 16'h0300, 0, 0);
        step("R9");
        chk("R9 bypass one edge", {msp_out, lsp_out}, 32'h0006_0000);
        bypass = 0; msp_sel_lo = 1;
        set_ops(16'h1234, 0, 16'h0010, 0, 0);
        step("R10"); step("R10");
        chk("R10 lower on msp", {16'h0, msp_out}, 32'h0000_2340);
        oe_msp_n = 1; oe_lsp_n = 1;
        step("R11");
        chk("R11 disabled", {msp_out, lsp_out}, 32'h0);
        quiet();

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            string tag;
            a_in       = 16'($urandom);
            b_in       = 16'($urandom);
            a_signed   = 1'($urandom);
            b_signed   = 1'($urandom);
            round_en   = 1'($urandom);
            full_fmt   = 1'($urandom);
            hold_a     = ($urandom % 5) == 0;
            hold_b     = ($urandom % 5) == 0;
            hold_res   = ($urandom % 6) == 0;
            bypass     = ($urandom % 4) == 0;
            msp_sel_lo = 1'($urandom);
            oe_msp_n   = ($urandom % 8) == 0;
            oe_lsp_n   = ($urandom % 8) == 0;
            rst        = ($urandom % 400) == 0;
            if (rst) tag = "R13";
            else if (bypass && !hold_res) tag = "R9";
            else if (full_fmt) tag = "R6";
            else tag = "R7";
            step(tag);
        end
        rst = 0;

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule